// File: doc/BRIEF.md
# GPIO Interrupt and Wake-up Detector

This block samples sixteen general-purpose input pins on its own clock. It reduces them to two level outputs: one combined interrupt request and one wake-up event. Each pin is qualified by four controls: an enable, a mask, a trigger mode (level or edge) and a polarity.

A per-pin status vector records which pins currently hold a request. Software can read it to find the cause of an interrupt. Edge-captured status is sticky until software writes a 1 to that bit. The wake-up output uses a stricter qualification, because each pin also needs its hibernate-enable bit set. The power controller that consumes this output only looks at it while the system is in hibernate.

All registers sit behind a simple single-cycle register bus. Writes take effect on the clock edge that samples them. Read data is registered and shows the addressed register one cycle after the address is presented.

Top module: `pin_irq_wake`

## Requirements
- R1: After synchronous reset, every control register and the status vector read 0, and `irq_o` and `wake_o` are 0.
- R2: Register addresses are 0 enable, 1 mask (1 = unmasked), 2 mode (1 = edge, 0 = level), 3 polarity (1 = high level or rising edge, 0 = low level or falling edge), 4 status and 5 hibernate-enable. A written value reads back one cycle after its address is presented, and addresses 6 and 7 read 0.
- R3: For an enabled level-mode pin, status is 1 exactly when the sampled pin equals its polarity bit, one clock after sampling. Writing 1 to such a status bit has no effect.
- R4: For an enabled edge-mode pin, the selected edge between two consecutive samples sets its status bit. The bit stays set after the pin returns to its previous level. An edge in the opposite direction sets nothing.
- R5: Writing 1 to an edge-mode status bit at address 4 clears it. If an edge arrives in the same cycle as the clear, the edge wins and the bit stays set.
- R6: A pin whose enable bit is 0 shows status 0. Clearing the enable bit also discards a pending edge status.
- R7: `irq_o` is the OR of status bits whose mask bit is 1, registered one clock after status. A masked but enabled pin still shows its status.
- R8: `wake_o` is the OR of status bits whose mask bit and hibernate-enable bit are both 1, registered with the same timing as `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| pins_i | input | 16 | Input pins, sampled on `clk` |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| irq_o | output | 1 | Combined interrupt request |
| wake_o | output | 1 | Wake-up event |

## Verification
A corrupted status bit shows up on the status readback two cycles after the pin change at the latest. It shows up on `irq_o` and `wake_o` one cycle after status, unless it is masked. A wrong previous-sample register shows up as a missed or spurious edge capture. Because edge capture is sticky, that error stays visible on the readback until software clears it. A stuck enable or mode bit appears as a level bit that does not follow its pin, or as an edge bit that survives being disabled.

// File: rtl/piw_pkg.sv
package piw_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_EN   = 3'd0,
    A_MASK = 3'd1,
    A_MODE = 3'd2,
    A_POL  = 3'd3,
    A_STAT = 3'd4,
    A_HIB  = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/piw_regs.sv
module piw_regs
  import piw_pkg::*;
#(
  parameter int N_PINS = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [N_PINS-1:0] wdata,
  input  logic [N_PINS-1:0] stat_in,
  output logic [N_PINS-1:0] en_q,
  output logic [N_PINS-1:0] msk_q,
  output logic [N_PINS-1:0] mode_q,
  output logic [N_PINS-1:0] pol_q,
  output logic [N_PINS-1:0] hib_q,
  output logic [N_PINS-1:0] clr,
  output logic [N_PINS-1:0] rdata
);
  logic [N_PINS-1:0] rd_mux;

  // write-one-to-clear pulses towards the pin cells
  assign clr = (we && addr == A_STAT) ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      msk_q  <= '0;
      mode_q <= '0;
      pol_q  <= '0;
      hib_q  <= '0;
    end else if (we) begin
      case (addr)
        A_EN:    en_q   <= wdata;
        A_MASK:  msk_q  <= wdata;
        A_MODE:  mode_q <= wdata;
        A_POL:   pol_q  <= wdata;
        A_HIB:   hib_q  <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      A_EN:    rd_mux = en_q;
      A_MASK:  rd_mux = msk_q;
      A_MODE:  rd_mux = mode_q;
      A_POL:   rd_mux = pol_q;
      A_STAT:  rd_mux = stat_in;
      A_HIB:   rd_mux = hib_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end

  // R2
  en_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (we && addr == A_EN) |=> (en_q == $past(wdata)));
endmodule

// File: rtl/piw_pin_cell.sv
module piw_pin_cell (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic en,
  input  logic mode,
  input  logic pol,
  input  logic clr,
  output logic stat
);
  logic prev;
  logic lvl_hit;
  logic edge_hit;

  assign lvl_hit  = (pin == pol);
  assign edge_hit = pol ? (pin & ~prev) : (~pin & prev);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev <= 1'b0;
      stat <= 1'b0;
    end else begin
      prev <= pin;
      if (!en)       stat <= 1'b0;
      else if (!mode) stat <= lvl_hit;
      else           stat <= edge_hit | (stat & ~clr);
    end
  end

  // R6
  off_clears_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> !stat);

  // R4
  edge_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (en && mode && stat && !clr) |=> stat);

  // R3
  lvl_track_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !mode) |=> (stat == $past(pin == pol)));
endmodule

// File: rtl/piw_combine.sv
module piw_combine #(
  parameter int N_PINS = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_PINS-1:0] stat,
  input  logic [N_PINS-1:0] msk,
  input  logic [N_PINS-1:0] hib,
  output logic              irq,
  output logic              wake
);
  logic [N_PINS-1:0] live;

  assign live = stat & msk;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq  <= 1'b0;
      wake <= 1'b0;
    end else begin
      irq  <= |live;
      wake <= |(live & hib);
    end
  end

  // R8
  wake_needs_irq_chk: assert property (@(posedge clk) disable iff (rst)
    wake |-> irq);

  // R7
  irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (|(stat & msk)) |=> irq);

  // R7
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !(|(stat & msk)) |=> !irq);
endmodule

// File: rtl/pin_irq_wake.sv
module pin_irq_wake
  import piw_pkg::*;
#(
  parameter int N_PINS = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_PINS-1:0] pins_i,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [N_PINS-1:0] bus_wdata,
  output logic [N_PINS-1:0] bus_rdata,
  output logic              irq_o,
  output logic              wake_o
);
  logic [N_PINS-1:0] en_q, msk_q, mode_q, pol_q, hib_q, clr, stat;

  piw_regs #(.N_PINS(N_PINS)) u_regs (
    .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .stat_in(stat), .en_q(en_q), .msk_q(msk_q), .mode_q(mode_q),
    .pol_q(pol_q), .hib_q(hib_q), .clr(clr), .rdata(bus_rdata)
  );

  for (genvar g = 0; g < N_PINS; g++) begin : g_pin
    piw_pin_cell u_cell (
      .clk(clk), .rst(rst), .pin(pins_i[g]), .en(en_q[g]),
      .mode(mode_q[g]), .pol(pol_q[g]), .clr(clr[g]), .stat(stat[g])
    );
  end

  piw_combine #(.N_PINS(N_PINS)) u_comb (
    .clk(clk), .rst(rst), .stat(stat), .msk(msk_q), .hib(hib_q),
    .irq(irq_o), .wake(wake_o)
  );
endmodule

// File: tb/sim_pin_irq_wake.sv
module sim_pin_irq_wake;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] pins = '0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq, wake;
  int          n_run = 0;
  int          n_fail = 0;

  always #2.5 clk = ~clk;

  pin_irq_wake u0 (
    .clk(clk), .rst(rst), .pins_i(pins), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq), .wake_o(wake)
  );

  typedef struct packed {
    logic [15:0] en, msk, mode, pol, hib, pa, pb, xs;
    logic        xi, xw;
  } vec_t;

  localparam vec_t TBL [7] = '{
    '{16'h000F, 16'h000F, 16'h0000, 16'h000F, 16'h0000, 16'h0000, 16'h0005, 16'h0005, 1'b1, 1'b0},
    '{16'h00F0, 16'h0000, 16'h0000, 16'h0000, 16'h00F0, 16'h0000, 16'h0030, 16'h00C0, 1'b0, 1'b0},
    '{16'hFF00, 16'hFF00, 16'hFF00, 16'hFF00, 16'h0100, 16'h0000, 16'h0300, 16'h0300, 1'b1, 1'b1},
    '{16'hFF00, 16'h0000, 16'hFF00, 16'h0000, 16'hFF00, 16'hFF00, 16'hF000, 16'h0F00, 1'b0, 1'b0},
    '{16'h0000, 16'hFFFF, 16'h0000, 16'hFFFF, 16'hFFFF, 16'h0000, 16'hFFFF, 16'h0000, 1'b0, 1'b0},
    '{16'hFFFF, 16'h00FF, 16'hFF00, 16'hFFFF, 16'h0080, 16'h0000, 16'h8080, 16'h8080, 1'b1, 1'b1},
    '{16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'h0000, 16'h00FF, 16'h0000, 16'h0000, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] v;
    wait_n(3);
    rst = 1'b0;
    // R1 reset state
    check("R1 irq", irq, 0);
    check("R1 wake", wake, 0);
    for (int a = 0; a < 6; a++) begin
      rd(a[2:0], v);
      check("R1 reg", v, 0);
    end
    // R2 readback and unused address
    wr(3'd0, 16'hA5A5);
    rd(3'd0, v);
    check("R2 enable readback", v, 16'hA5A5);
    wr(3'd5, 16'h3C3C);
    rd(3'd5, v);
    check("R2 hib readback", v, 16'h3C3C);
    wr(3'd7, 16'hFFFF);
    rd(3'd7, v);
    check("R2 unused addr", v, 0);

    // table: R3 R4 R6 R7 R8
    for (int i = 0; i < 7; i++) begin
      pins = TBL[i].pa;
      wait_n(2);
      wr(3'd0, TBL[i].en);
      wr(3'd1, TBL[i].msk);
      wr(3'd2, TBL[i].mode);
      wr(3'd3, TBL[i].pol);
      wr(3'd5, TBL[i].hib);
      wr(3'd4, 16'hFFFF);
      pins = TBL[i].pb;
      wait_n(2);
      rd(3'd4, v);
      check($sformatf("R3/R4/R6 vec%0d status", i), v, TBL[i].xs);
      check($sformatf("R7 vec%0d irq", i), irq, TBL[i].xi);
      check($sformatf("R8 vec%0d wake", i), wake, TBL[i].xw);
    end

    // directed edge tests on pin 0
    pins = '0;
    wait_n(2);
    wr(3'd0, 16'h0001);
    wr(3'd1, 16'h0001);
    wr(3'd2, 16'h0001);
    wr(3'd3, 16'h0001);
    wr(3'd5, 16'h0000);
    wr(3'd4, 16'hFFFF);
    pins = 16'h0001;
    wait_n(2);
    rd(3'd4, v);
    check("R4 rising capture", v, 16'h0001);
    check("R7 irq on edge", irq, 1);
    pins = '0;
    wait_n(2);
    rd(3'd4, v);
    check("R4 sticky after release", v, 16'h0001);
    wr(3'd4, 16'h0001);
    rd(3'd4, v);
    check("R5 w1c clears", v, 0);
    wait_n(1);
    check("R7 irq drops", irq, 0);
    // R5 simultaneous edge and clear
    @(negedge clk);
    pins = 16'h0001; we = 1'b1; addr = 3'd4; wdata = 16'h0001;
    @(negedge clk);
    we = 1'b0;
    rd(3'd4, v);
    check("R5 edge beats clear", v, 16'h0001);
    // R6 disabling discards pending edge
    wr(3'd0, 16'h0000);
    wr(3'd0, 16'h0001);
    rd(3'd4, v);
    check("R6 pending discarded", v, 0);
    // R3 level bit ignores w1c
    wr(3'd2, 16'h0000);
    wait_n(1);
    wr(3'd4, 16'hFFFF);
    rd(3'd4, v);
    check("R3 level ignores w1c", v, 16'h0001);
    // R1 reset clears live state
    @(negedge clk); rst = 1'b1;
    wait_n(2);
    rst = 1'b0;
    rd(3'd4, v);
    check("R1 status after reset", v, 0);
    check("R1 irq after reset", irq, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule